// File: doc/BRIEF.md
# Fixed-Direction GPIO Register Bank

This block is a general-purpose I/O controller for 24 pin positions, each given a direction when the block is built. Pins 0 to 8 and 11 to 13 are inputs only. Pins 16 to 23 are outputs only. Pins 9, 10, 14 and 15 do not exist. Software reaches four 24-bit control registers through a 64-byte window on a simple byte-wide bus. The window's base comes from a base value held outside the block.

A use-select register hands selected pins to their alternate functions. Input pins 0 to 5 and 11 can be routed to alternate-function logic, and output pins 16 and 17 can be driven from two alternate grant signals. Each input passes through a two-flop synchronizer and then a per-pin polarity inverter. It then sets a sticky event status bit, which software clears by writing 1 to it. Each output follows its bit in a level register. Pin 21 comes out of reset high. Pin 22 is open-drain: it either pulls low or floats.

Top module: `gpio_fixed_bank`

## Requirements
- R1: An access hits only when `bus_sel` is 1 and `bus_addr[15:6]` equals `win_base`. Within the window, the registers sit at these offsets: use-select at 0x00, output level at 0x04, input polarity at 0x08 and event status at 0x0C. Offset +k of a register (k = 0 to 2) holds bits 8k+7 to 8k. Byte +3 and every other offset read 0. A miss reads 0 and changes nothing.
- R2: After reset, use-select, polarity and status are 0, and the level register is 0x200000, so only pin 21 is high.
- R3: Use-select keeps only bits 0-5 and 11. Level keeps only bits 16-23. Polarity and status keep only bits 0-8 and 11-13. Every other bit reads 0 and ignores writes, and an unimplemented input pin never sets status.
- R4: An input pin's level reaches the status logic through two flops. Status bit N sets at the third rising edge after pin N changes, when pin N XOR polarity bit N is 1.
- R5: A status bit stays set until software writes 1 to it. Writing 0 has no effect. If the event is still active in the cycle of the clearing write, the bit stays set.
- R6: While use-select bit N is set for an input pin, that pin's event does not set status and `alt_in[N]` carries the synchronized pin. In every other case `alt_in[N]` is 0.
- R7: Output pins 16-21 and 23 are push-pull: `pad_oe` is 1 and `pad_out` equals the level bit.
- R8: Pin 22 is open-drain: level 0 gives `pad_oe`=1 and `pad_out`=0, and level 1 gives `pad_oe`=0 and `pad_out`=0.
- R9: While use-select bit 0 (or bit 1) is set, pin 16 (or pin 17) follows `alt_gnt[0]` (or `alt_gnt[1]`) instead of its level bit.
- R10: Input and unimplemented positions (bits 0-15) always have `pad_oe`=0 and `pad_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| win_base | input | 10 | Window base, address bits 15:6 |
| pin_in | input | 24 | Pin levels, asynchronous |
| pad_out | output | 24 | Pad output value |
| pad_oe | output | 24 | Pad output enable |
| alt_in | output | 24 | Synchronized inputs given to alternate functions |
| alt_gnt | input | 2 | Alternate drive for pins 16 and 17 |

## Verification
Register writes take effect at the clock edge that ends the write cycle. From the next cycle on, they show on `pad_out`, `pad_oe` and in read data, which is combinational. A pin change shows on `alt_in` after two rising edges and in the status register after three. The bench therefore changes pins on a falling edge and waits three full cycles before reading status. It samples every output shortly after a falling edge, well away from the active edge. The set-over-clear race is tested by writing a clear while the pin stays active and then reading the bit back.

// File: rtl/gpio_fixed_bank.sv
module gpio_fixed_bank #(
  parameter int          AW        = 16,
  parameter int          WIN_AW    = 6,
  parameter int          NP        = 24,
  parameter logic [23:0] IN_MASK   = 24'h0039FF,
  parameter logic [23:0] OUT_MASK  = 24'hFF0000,
  parameter logic [23:0] USE_MASK  = 24'h00083F,
  parameter logic [23:0] OD_MASK   = 24'h400000,
  parameter logic [23:0] LVL_RST   = 24'h200000,
  parameter int          GNT0_PIN  = 16,
  parameter int          GNT1_PIN  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [AW-WIN_AW-1:0] win_base,
  input  logic [NP-1:0]    pin_in,
  output logic [NP-1:0]    pad_out,
  output logic [NP-1:0]    pad_oe,
  output logic [NP-1:0]    alt_in,
  input  logic [1:0]       alt_gnt
);
  localparam int RSW = WIN_AW - 2;

  logic [NP-1:0] use_q, lvl_q, inv_q, st_q;
  logic [NP-1:0] s1_q, s2_q;

  logic [WIN_AW-1:0] off;
  logic [RSW-1:0]    rsel;
  logic [1:0]        lane;
  logic              hit, wr_en;
  logic              wr_use, wr_lvl, wr_inv, wr_st;
  logic [NP-1:0]     bm, wd, act, drv;
  logic [31:0]       rd_word, rd_shift;

  assign off    = bus_addr[WIN_AW-1:0];
  assign rsel   = off[WIN_AW-1:2];
  assign lane   = off[1:0];
  assign hit    = bus_sel && (bus_addr[AW-1:WIN_AW] == win_base);
  assign wr_en  = hit && bus_wr;
  assign wr_use = wr_en && (rsel == RSW'(0));
  assign wr_lvl = wr_en && (rsel == RSW'(1));
  assign wr_inv = wr_en && (rsel == RSW'(2));
  assign wr_st  = wr_en && (rsel == RSW'(3));

  logic [31:0] bm32;
  assign bm32 = 32'hFF << {lane, 3'b000};
  assign bm   = bm32[NP-1:0];
  assign wd   = {(NP/8){bus_wdata}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in & IN_MASK;
      s2_q <= s1_q;
    end
  end

  assign act    = (s2_q ^ inv_q) & ~use_q & IN_MASK;
  assign alt_in = s2_q & use_q & IN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= '0;
      lvl_q <= LVL_RST & OUT_MASK;
      inv_q <= '0;
      st_q  <= '0;
    end else begin
      if (wr_use) use_q <= ((use_q & ~bm) | (wd & bm)) & USE_MASK;
      if (wr_lvl) lvl_q <= ((lvl_q & ~bm) | (wd & bm)) & OUT_MASK;
      if (wr_inv) inv_q <= ((inv_q & ~bm) | (wd & bm)) & IN_MASK;
      st_q <= ((st_q & ~(wr_st ? (wd & bm) : '0)) | act) & IN_MASK;
    end
  end

  always_comb begin
    case (rsel)
      RSW'(0): rd_word = 32'(use_q);
      RSW'(1): rd_word = 32'(lvl_q);
      RSW'(2): rd_word = 32'(inv_q);
      RSW'(3): rd_word = 32'(st_q);
      default: rd_word = '0;
    endcase
  end
  assign rd_shift  = rd_word >> {lane, 3'b000};
  assign bus_rdata = hit ? rd_shift[7:0] : 8'h00;

  always_comb begin
    drv = lvl_q;
    if (use_q[0]) drv[GNT0_PIN] = alt_gnt[0];
    if (use_q[1]) drv[GNT1_PIN] = alt_gnt[1];
  end

  assign pad_out = drv & OUT_MASK & ~OD_MASK;
  assign pad_oe  = OUT_MASK & (~OD_MASK | ~drv);

  p_miss_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(use_q) && $stable(lvl_q) && $stable(inv_q)));

  p_masked_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((use_q & ~USE_MASK) | (lvl_q & ~OUT_MASK) | (inv_q & ~IN_MASK) | (st_q & ~IN_MASK)) == '0);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> ((st_q & $past(st_q)) == $past(st_q)));

  p_alt_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_in & ~use_q) == '0);

  p_open_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q[22] |-> (!pad_oe[22] && !pad_out[22]));

  p_inputs_undriven_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[15:0] == '0) && (pad_out[15:0] == '0));
endmodule

// File: tb/tb_gpio_fixed_bank.sv
module tb_gpio_fixed_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [9:0]  win_base = 10'h2A;
  logic [23:0] pin_in = '0;
  logic [23:0] pad_out, pad_oe, alt_in;
  logic [1:0]  alt_gnt = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [15:0] BASE = {10'h2A, 6'h00};

  always #5 clk = ~clk;

  gpio_fixed_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win_base(win_base), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_in(alt_in), .alt_gnt(alt_gnt));

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(BASE + 16'h00, d); check("R2", "use b0", d, 8'h00);
    rd(BASE + 16'h06, d); check("R2", "level b2", d, 8'h20);
    rd(BASE + 16'h0C, d); check("R2", "status b0", d, 8'h00);
    #1;
    check("R7", "pad_out reset", pad_out, 24'h200000);
    check("R8", "pad_oe reset", pad_oe, 24'hFF0000);
    check("R10", "low pads", {pad_oe[15:0], pad_out[15:0]}, 32'h0);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    wr({10'h15, 6'h06}, 8'hFF);
    rd(BASE + 16'h06, d); check("R1", "miss write ignored", d, 8'h20);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = {10'h15, 6'h06};
    #1 check("R1", "miss reads 0", bus_rdata, 8'h00);
    bus_sel = 0;
    rd(BASE + 16'h20, d); check("R1", "unmapped offset", d, 8'h00);
    rd(BASE + 16'h07, d); check("R1", "byte 3 reads 0", d, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] d;
    for (int i = 0; i < 3; i++) begin
      wr(BASE + 16'(i), 8'hFF);
      wr(BASE + 16'h08 + 16'(i), 8'hFF);
    end
    rd(BASE + 16'h00, d); check("R3", "use b0", d, 8'h3F);
    rd(BASE + 16'h01, d); check("R3", "use b1", d, 8'h08);
    rd(BASE + 16'h02, d); check("R3", "use b2", d, 8'h00);
    rd(BASE + 16'h08, d); check("R3", "inv b0", d, 8'hFF);
    rd(BASE + 16'h09, d); check("R3", "inv b1", d, 8'h39);
    rd(BASE + 16'h0A, d); check("R3", "inv b2", d, 8'h00);
    wr(BASE + 16'h04, 8'hFF);
    rd(BASE + 16'h04, d); check("R3", "level b0", d, 8'h00);
    for (int i = 0; i < 3; i++) begin
      wr(BASE + 16'h08 + 16'(i), 8'h00);
      wr(BASE + 16'(i), 8'h00);
    end
    settle();
    for (int i = 0; i < 3; i++) wr(BASE + 16'h0C + 16'(i), 8'hFF);
    rd(BASE + 16'h0C, d); check("R3", "status cleared", d, 8'h00);
  endtask

  task automatic t_level();
    wr(BASE + 16'h06, 8'hA5);
    #1;
    check("R7", "pad_out A5", pad_out, 24'hA50000);
    check("R8", "pad_oe A5", pad_oe, 24'hFF0000);
    wr(BASE + 16'h06, 8'hC3);
    #1;
    check("R8", "pad_out C3", pad_out, 24'h830000);
    check("R8", "pad_oe C3 pin22 floats", pad_oe, 24'hBF0000);
    check("R10", "inputs undriven", {pad_oe[15:0], pad_out[15:0]}, 32'h0);
    wr(BASE + 16'h06, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] d;
    pin_in[3] = 1;
    @(negedge clk); @(negedge clk);
    #1 rd(BASE + 16'h0C, d);
    settle();
    rd(BASE + 16'h0C, d); check("R4", "pin3 event", d, 8'h08);
    pin_in[3] = 0; settle();
    rd(BASE + 16'h0C, d); check("R5", "sticky after release", d, 8'h08);
    wr(BASE + 16'h0C, 8'h00);
    rd(BASE + 16'h0C, d); check("R5", "write 0 no effect", d, 8'h08);
    wr(BASE + 16'h0C, 8'h08);
    rd(BASE + 16'h0C, d); check("R5", "write 1 clears", d, 8'h00);
    wr(BASE + 16'h09, 8'h10); settle();
    rd(BASE + 16'h0D, d); check("R4", "inverted pin12 low", d, 8'h10);
    wr(BASE + 16'h09, 8'h00); wr(BASE + 16'h0D, 8'h10);
    rd(BASE + 16'h0D, d); check("R4", "cleared after inv off", d, 8'h00);
    pin_in[3] = 1; settle();
    wr(BASE + 16'h0C, 8'h08);
    rd(BASE + 16'h0C, d); check("R5", "set wins over clear", d, 8'h08);
    pin_in[3] = 0; settle();
    wr(BASE + 16'h0C, 8'h08);
    pin_in[9] = 1; pin_in[15] = 1; settle();
    rd(BASE + 16'h0D, d); check("R3", "unimpl pins no status", d, 8'h00);
    pin_in[9] = 0; pin_in[15] = 0;
  endtask

  task automatic t_input_timing();
    logic [7:0] d;
    @(negedge clk); pin_in[6] = 1;
    @(negedge clk); @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = BASE + 16'h0C;
    #1 check("R4", "status not yet after 2 edges", bus_rdata, 8'h00);
    bus_sel = 0;
    @(negedge clk);
    rd(BASE + 16'h0C, d); check("R4", "status after 3 edges", d, 8'h40);
    pin_in[6] = 0; settle();
    wr(BASE + 16'h0C, 8'h40);
  endtask

  task automatic t_alt();
    logic [7:0] d;
    wr(BASE + 16'h00, 8'h04);
    pin_in[2] = 1; settle();
    rd(BASE + 16'h0C, d); check("R6", "owned pin no status", d, 8'h00);
    check("R6", "alt_in carries pin", alt_in, 24'h000004);
    wr(BASE + 16'h00, 8'h00);
    #1 check("R6", "alt_in zero when released", alt_in, 24'h0);
    settle();
    rd(BASE + 16'h0C, d); check("R6", "released pin sets status", d, 8'h04);
    pin_in[2] = 0; settle();
    wr(BASE + 16'h0C, 8'h04);
    wr(BASE + 16'h06, 8'h00);
    wr(BASE + 16'h00, 8'h03);
    alt_gnt = 2'b01; #1;
    check("R9", "gnt pins 01", pad_out[17:16], 2'b01);
    alt_gnt = 2'b10; #1;
    check("R9", "gnt pins 10", pad_out[17:16], 2'b10);
    wr(BASE + 16'h00, 8'h00);
    #1 check("R9", "level restored", pad_out[17:16], 2'b00);
    alt_gnt = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_masks();
    t_level();
    t_input();
    t_input_timing();
    t_alt();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule